// File: doc/BRIEF.md
# Erase Suspend Command Controller

This block decodes bus write cycles for a flash-style memory and tracks a block erase through suspend and resume. Each write presents an address, a data byte and a one-cycle strobe. The block keeps a status byte and a read mode. It drives a busy level and start pulses toward an array engine. Array timing for erase, program and suspend latency comes from internal down-counters.

An erase is opened with a two-write sequence. While the erase runs it may be suspended. Once the suspend latency has elapsed, the set of legal commands narrows. Array reads of the suspended block are masked. A single program may be run to any other block. A resume command continues the erase from where it stopped. If the resume arrives while a nested program is still running, it is held and takes effect only when that program finishes.

Top module: `esc_ctrl`

## Requirements
- R1: After reset the busy output is low, reads return array data, and the status byte reads 80H. Status layout: bit 7 is ready, bit 6 is erase suspended, bit 5 is sequence/erase error, bit 4 is program error, and bits 3..0 are zero.
- R2: Writing 40H or 10H and then one more write starts a program at that second write's address and data. The start pulse is high in the cycle after the data write. Busy stays high for PGM_CYCLES cycles, and the status is then 80H.
- R3: 20H followed by D0H starts an erase of the block in the upper address bits of the D0H write. Busy is high for ERASE_CYCLES cycles. 20H followed by any other byte sets bits 5 and 4 and starts nothing.
- R4: B0H during an erase keeps busy high for SUSP_LAT cycles, then sets bits 7 and 6. The erase counter does not advance from the B0H write until the resume.
- R5: While suspended in array read mode, any address in the suspended block reads FFH, and other blocks return array data.
- R6: While suspended, a program may target another block. During that program busy is high and bit 7 reads 0, and afterwards the block is suspended again (C0H). A program aimed at the suspended block starts nothing and sets bits 5 and 4.
- R7: While suspended, only FFH, 70H, 98H, 50H, B8H (plus one operand write), D0H and 40H/10H are accepted. Any other byte sets bits 5 and 4 and otherwise changes nothing.
- R8: D0H while suspended clears bits 7 and 6, raises busy, pulses the erase start with the same block and switches reads to status. The erase then finishes after its remaining cycles.
- R9: D0H written during a nested program is held. Bit 6 stays set and the erase does not restart until that program's last cycle ends, after which the erase continues with no idle gap.
- R10: 50H clears bits 5 and 4 and leaves bits 7 and 6 unchanged.
- R11: 70H selects status reads, 98H selects reads of the QUERY_ID parameter, and FFH selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data / command byte |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data (array, status or query) |
| arr_raddr_o | output | ADDR_W | Address forwarded to the array |
| arr_rdata_i | input | 8 | Array read data |
| sts_busy_o | output | 1 | High while an array operation is in progress |
| erase_start_o | output | 1 | Erase start or continue pulse |
| erase_blk_o | output | ADDR_W-BLK_SHIFT | Block being erased |
| pgm_start_o | output | 1 | Program start pulse |
| pgm_addr_o | output | ADDR_W | Program address |
| pgm_data_o | output | 8 | Program data |

## Verification
The erase path is driven three ways: run to completion, suspended and resumed directly, and suspended with a resume written during a nested program. Comparing busy lengths across these cases separates a frozen erase counter from one that keeps running or reloads. Inside the suspend, the bench writes legal codes, illegal codes, a configure whose operand is itself an illegal code, and programs to both the suspended block and another block. This distinguishes the narrowed command filter from two-write sequences that consume their operand. Array reads on both sides of a block boundary, taken just before and after a resume, show the block mask and the forced switch to status reads.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ERS_SETUP, S_ERASE, S_SUSP_WAIT, S_SUSP, S_PGM_SETUP, S_PGM,
    S_CFG_SETUP, S_SP_PGM_SETUP, S_SP_PGM, S_SP_CFG_SETUP
  } state_e;

  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_QUERY} rmode_e;

  typedef enum logic [3:0] {
    K_NONE, K_RD_ARRAY, K_RD_STATUS, K_RD_QUERY, K_CLR_STATUS, K_CONFIG,
    K_ERASE_SETUP, K_CONFIRM, K_PGM_SETUP, K_SUSPEND
  } cmd_e;

  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS = 8'h70;
  localparam logic [7:0] OP_RD_QUERY  = 8'h98;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_CONFIG    = 8'hB8;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_PGM       = 8'h40;
  localparam logic [7:0] OP_PGM_ALT   = 8'h10;
  localparam logic [7:0] OP_SUSPEND   = 8'hB0;

  localparam int SR_READY = 7;
  localparam int SR_SUSP  = 6;
  localparam int SR_ESEQ  = 5;
  localparam int SR_EPGM  = 4;
endpackage

// File: rtl/esc_cmd_decode.sv
module esc_cmd_decode
  import esc_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       kind_o,
  output logic       susp_ok_o
);
  always_comb begin
    case (code_i)
      OP_RD_ARRAY:          kind_o = K_RD_ARRAY;
      OP_RD_STATUS:         kind_o = K_RD_STATUS;
      OP_RD_QUERY:          kind_o = K_RD_QUERY;
      OP_CLR_STAT:          kind_o = K_CLR_STATUS;
      OP_CONFIG:            kind_o = K_CONFIG;
      OP_ERASE:             kind_o = K_ERASE_SETUP;
      OP_CONFIRM:           kind_o = K_CONFIRM;
      OP_PGM, OP_PGM_ALT:   kind_o = K_PGM_SETUP;
      OP_SUSPEND:           kind_o = K_SUSPEND;
      default:              kind_o = K_NONE;
    endcase
  end

  // narrowed set while an erase is parked
  always_comb begin
    case (kind_o)
      K_RD_ARRAY, K_RD_STATUS, K_RD_QUERY, K_CLR_STATUS,
      K_CONFIG, K_CONFIRM, K_PGM_SETUP: susp_ok_o = 1'b1;
      default:                          susp_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/esc_timer.sv
module esc_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          run_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(1));

  AST_TMR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/esc_status.sv
module esc_status
  import esc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic       set_susp_i,
  input  logic       clr_susp_i,
  input  logic       set_err_i,
  input  logic       clr_err_i,
  output logic [7:0] sr_o
);
  logic susp_q, eseq_q, epgm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      eseq_q <= 1'b0;
      epgm_q <= 1'b0;
    end else begin
      if (set_susp_i)      susp_q <= 1'b1;
      else if (clr_susp_i) susp_q <= 1'b0;
      if (set_err_i) begin
        eseq_q <= 1'b1;
        epgm_q <= 1'b1;
      end else if (clr_err_i) begin
        eseq_q <= 1'b0;
        epgm_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sr_o           = '0;
    sr_o[SR_READY] = ready_i;
    sr_o[SR_SUSP]  = susp_q;
    sr_o[SR_ESEQ]  = eseq_q;
    sr_o[SR_EPGM]  = epgm_q;
  end

  AST_SUSP_ONLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_o[SR_SUSP]) |-> sr_o[SR_READY]); // R4
  AST_CLR_KEEPS_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !set_err_i && !set_susp_i && !clr_susp_i) |=>
      (!sr_o[SR_ESEQ] && !sr_o[SR_EPGM] && $stable(sr_o[SR_SUSP]))); // R10
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter int         BLK_SHIFT    = 8,
  parameter int         ERASE_CYCLES = 40,
  parameter int         PGM_CYCLES   = 10,
  parameter int         SUSP_LAT     = 4,
  parameter logic [7:0] QUERY_ID     = 8'h51
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [7:0]                  wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [7:0]                  rd_data_o,
  output logic [ADDR_W-1:0]           arr_raddr_o,
  input  logic [7:0]                  arr_rdata_i,
  output logic                        sts_busy_o,
  output logic                        erase_start_o,
  output logic [ADDR_W-BLK_SHIFT-1:0] erase_blk_o,
  output logic                        pgm_start_o,
  output logic [ADDR_W-1:0]           pgm_addr_o,
  output logic [7:0]                  pgm_data_o
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int TMAX  = (ERASE_CYCLES > PGM_CYCLES) ?
                         ((ERASE_CYCLES > SUSP_LAT) ? ERASE_CYCLES : SUSP_LAT) :
                         ((PGM_CYCLES > SUSP_LAT) ? PGM_CYCLES : SUSP_LAT);
  localparam int CW    = $clog2(TMAX + 1);
  localparam int T_ERS = 0;
  localparam int T_PGM = 1;
  localparam int T_LAT = 2;
  localparam int NTMR  = 3;

  function automatic int tmr_len(input int idx);
    case (idx)
      T_ERS:   return ERASE_CYCLES;
      T_PGM:   return PGM_CYCLES;
      default: return SUSP_LAT;
    endcase
  endfunction

  state_e            state_q, state_d;
  rmode_e            mode_q, mode_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic              resume_q, resume_d;
  cmd_e              kind;
  logic              susp_ok;
  logic [NTMR-1:0]   t_load, t_run, t_done;
  logic              set_err, clr_err, set_susp, clr_susp, ers_go, pgm_go;
  logic [7:0]        sr;
  logic              busy, parked;
  logic [BLK_W-1:0]  wr_blk, rd_blk;
  logic              ers_go_q, pgm_go_q;
  logic [ADDR_W-1:0] pgm_addr_q;
  logic [7:0]        pgm_data_q;

  assign wr_blk = wr_addr_i[ADDR_W-1:BLK_SHIFT];
  assign rd_blk = rd_addr_i[ADDR_W-1:BLK_SHIFT];

  esc_cmd_decode u_dec (
    .code_i    (wr_data_i),
    .kind_o    (kind),
    .susp_ok_o (susp_ok)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    esc_timer #(.CW(CW)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (t_load[g]),
      .val_i  (CW'(tmr_len(g))),
      .run_i  (t_run[g]),
      .done_o (t_done[g])
    );
  end

  assign t_run[T_ERS] = (state_q == S_ERASE);
  assign t_run[T_PGM] = (state_q == S_PGM) || (state_q == S_SP_PGM);
  assign t_run[T_LAT] = (state_q == S_SUSP_WAIT);

  assign busy   = (state_q == S_ERASE) || (state_q == S_SUSP_WAIT) ||
                  (state_q == S_PGM)   || (state_q == S_SP_PGM);
  assign parked = (state_q == S_SUSP) || (state_q == S_SP_PGM_SETUP) ||
                  (state_q == S_SP_PGM) || (state_q == S_SP_CFG_SETUP);

  esc_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (!busy),
    .set_susp_i (set_susp),
    .clr_susp_i (clr_susp),
    .set_err_i  (set_err),
    .clr_err_i  (clr_err),
    .sr_o       (sr)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    blk_d    = blk_q;
    resume_d = resume_q;
    t_load   = '0;
    set_err  = 1'b0;
    clr_err  = 1'b0;
    set_susp = 1'b0;
    clr_susp = 1'b0;
    ers_go   = 1'b0;
    pgm_go   = 1'b0;
    case (state_q)
      S_IDLE: if (wr_en_i) begin
        case (kind)
          K_RD_ARRAY:    mode_d = M_ARRAY;
          K_RD_STATUS:   mode_d = M_STATUS;
          K_RD_QUERY:    mode_d = M_QUERY;
          K_CLR_STATUS:  clr_err = 1'b1;
          K_CONFIG:      state_d = S_CFG_SETUP;
          K_ERASE_SETUP: begin state_d = S_ERS_SETUP; mode_d = M_STATUS; end
          K_PGM_SETUP:   begin state_d = S_PGM_SETUP; mode_d = M_STATUS; end
          default: ;
        endcase
      end
      S_CFG_SETUP: if (wr_en_i) state_d = S_IDLE;
      S_ERS_SETUP: if (wr_en_i) begin
        if (kind == K_CONFIRM) begin
          state_d       = S_ERASE;
          blk_d         = wr_blk;
          t_load[T_ERS] = 1'b1;
          ers_go        = 1'b1;
        end else begin
          state_d = S_IDLE;
          set_err = 1'b1;
        end
      end
      S_ERASE: begin
        if (t_done[T_ERS]) state_d = S_IDLE;
        else if (wr_en_i && kind == K_SUSPEND) begin
          state_d       = S_SUSP_WAIT;
          t_load[T_LAT] = 1'b1;
          mode_d        = M_STATUS;
        end
      end
      S_SUSP_WAIT: if (t_done[T_LAT]) begin
        state_d  = S_SUSP;
        set_susp = 1'b1;
      end
      S_PGM_SETUP: if (wr_en_i) begin
        state_d       = S_PGM;
        t_load[T_PGM] = 1'b1;
        pgm_go        = 1'b1;
      end
      S_PGM: if (t_done[T_PGM]) state_d = S_IDLE;
      S_SUSP: if (wr_en_i) begin
        if (!susp_ok) set_err = 1'b1;
        else begin
          case (kind)
            K_RD_ARRAY:   mode_d = M_ARRAY;
            K_RD_STATUS:  mode_d = M_STATUS;
            K_RD_QUERY:   mode_d = M_QUERY;
            K_CLR_STATUS: clr_err = 1'b1;
            K_CONFIG:     state_d = S_SP_CFG_SETUP;
            K_PGM_SETUP:  begin state_d = S_SP_PGM_SETUP; mode_d = M_STATUS; end
            K_CONFIRM: begin
              state_d  = S_ERASE;
              clr_susp = 1'b1;
              ers_go   = 1'b1;
              mode_d   = M_STATUS;
            end
            default: ;
          endcase
        end
      end
      S_SP_CFG_SETUP: if (wr_en_i) state_d = S_SUSP;
      S_SP_PGM_SETUP: if (wr_en_i) begin
        if (wr_blk == blk_q) begin
          state_d = S_SUSP;
          set_err = 1'b1;
        end else begin
          state_d       = S_SP_PGM;
          t_load[T_PGM] = 1'b1;
          pgm_go        = 1'b1;
        end
      end
      S_SP_PGM: begin
        if (t_done[T_PGM]) begin
          if (resume_q || (wr_en_i && kind == K_CONFIRM)) begin
            state_d  = S_ERASE;
            clr_susp = 1'b1;
            ers_go   = 1'b1;
            resume_d = 1'b0;
            mode_d   = M_STATUS;
          end else state_d = S_SUSP;
        end else if (wr_en_i && kind == K_CONFIRM) resume_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_q     <= M_ARRAY;
      blk_q      <= '0;
      resume_q   <= 1'b0;
      ers_go_q   <= 1'b0;
      pgm_go_q   <= 1'b0;
      pgm_addr_q <= '0;
      pgm_data_q <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      blk_q    <= blk_d;
      resume_q <= resume_d;
      ers_go_q <= ers_go;
      pgm_go_q <= pgm_go;
      if (pgm_go) begin
        pgm_addr_q <= wr_addr_i;
        pgm_data_q <= wr_data_i;
      end
    end
  end

  always_comb begin
    case (mode_q)
      M_STATUS: rd_data_o = sr;
      M_QUERY:  rd_data_o = QUERY_ID;
      default:  rd_data_o = (parked && rd_blk == blk_q) ? 8'hFF : arr_rdata_i;
    endcase
  end

  assign arr_raddr_o   = rd_addr_i;
  assign sts_busy_o    = busy;
  assign erase_start_o = ers_go_q;
  assign erase_blk_o   = blk_q;
  assign pgm_start_o   = pgm_go_q;
  assign pgm_addr_o    = pgm_addr_q;
  assign pgm_data_o    = pgm_data_q;

  AST_SP_PGM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SP_PGM) |-> (sts_busy_o && !sr[SR_READY])); // R6
  AST_PGM_OFF_SUSP_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_start_o && sr[SR_SUSP]) |-> (pgm_addr_o[ADDR_W-1:BLK_SHIFT] != blk_q)); // R6
  AST_ILLEGAL_SUSP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SUSP && wr_en_i && !susp_ok) |=>
      (sr[SR_ESEQ] && sr[SR_EPGM] && state_q == S_SUSP)); // R7
  AST_RESUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(erase_start_o) && $past(state_q) != S_ERS_SETUP) |->
      (!sr[SR_SUSP] && !sr[SR_READY])); // R8
  AST_NO_EARLY_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SP_PGM && !t_done[T_PGM]) |=> (state_q != S_ERASE)); // R9
  AST_HELD_RESUME_KEEPS_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SP_PGM) |-> sr[SR_SUSP]); // R9
endmodule

// File: tb/esc_ctrl_tb_top.sv
module esc_ctrl_tb_top;
  localparam int         CLK_P = 10;
  localparam int         AW    = 12;
  localparam int         E     = 40;
  localparam int         N     = 10;
  localparam int         L     = 4;
  localparam logic [7:0] QID   = 8'h51;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data, arr_rdata;
  logic [AW-1:0] arr_raddr, pgm_addr;
  logic          busy, es, ps;
  logic [3:0]    eblk;
  logic [7:0]    pdata;
  int            n_tests = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [AW-1:0] a);
    return {1'b0, a[6:0]};
  endfunction
  assign arr_rdata = arr_fn(arr_raddr);

  esc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .arr_raddr_o(arr_raddr), .arr_rdata_i(arr_rdata), .sts_busy_o(busy),
    .erase_start_o(es), .erase_blk_o(eblk), .pgm_start_o(ps),
    .pgm_addr_o(pgm_addr), .pgm_data_o(pdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy", busy, 0);
    rd(12'h123, d); check("R1 array read", d, arr_fn(12'h123));
    check("R1 no starts", {es, ps}, 0);
    wr(0, 8'h70); rd(0, d); check("R1/R11 status", d, 8'h80);
  endtask

  task automatic t_program();
    int n; logic [7:0] d;
    wr(0, 8'h10); wr(12'h2A7, 8'h3C);
    check("R2 pulse", ps, 1); check("R2 addr", pgm_addr, 12'h2A7);
    check("R2 data", pdata, 8'h3C);
    count_busy(n); check("R2 busy len", n, N);
    check("R2 pulse drop", ps, 0);
    rd(0, d); check("R2 status", d, 8'h80);
    wr(0, 8'h40); wr(12'h011, 8'h5E);
    check("R2 alt pulse", ps, 1);
    count_busy(n); check("R2 40H busy len", n, N);
  endtask

  task automatic t_erase();
    int n; logic [7:0] d;
    wr(12'h300, 8'h20); wr(12'h345, 8'hD0);
    check("R3 start", es, 1); check("R3 blk", eblk, 4'h3);
    count_busy(n); check("R3 busy len", n, E);
    rd(0, d); check("R3 status", d, 8'h80);
    wr(0, 8'h20); wr(0, 8'hFF);
    check("R3 bad confirm no start", {es, busy}, 0);
    rd(0, d); check("R3 bad confirm err", d, 8'hB0);
    wr(0, 8'h50); rd(0, d); check("R10 clear", d, 8'h80);
  endtask

  task automatic suspend_erase(input logic [AW-1:0] a, input int dly);
    int n; logic [7:0] d;
    wr(a, 8'h20); wr(a, 8'hD0);
    for (int i = 0; i < dly; i++) @(negedge clk);
    wr(0, 8'hB0);
    count_busy(n); check("R4 latency", n, L);
    rd(0, d); check("R4 suspended status", d, 8'hC0);
  endtask

  task automatic t_suspend_resume();
    int n; logic [7:0] d;
    suspend_erase(12'h500, 5);
    wr(0, 8'hFF);
    rd(12'h510, d); check("R5 masked block", d, 8'hFF);
    rd(12'h5FF, d); check("R5 masked block top", d, 8'hFF);
    rd(12'h710, d); check("R5 other block", d, arr_fn(12'h710));
    rd(12'h4FF, d); check("R5 neighbour block", d, arr_fn(12'h4FF));
    wr(0, 8'h98); rd(0, d); check("R11 query", d, QID);
    wr(0, 8'h70); wr(0, 8'h20);
    check("R7 no start", {es, ps, busy}, 0);
    rd(0, d); check("R7 illegal 20H", d, 8'hF0);
    wr(0, 8'h50); rd(0, d); check("R10 clear keeps susp", d, 8'hC0);
    wr(0, 8'hB0); rd(0, d); check("R7 illegal B0H", d, 8'hF0);
    wr(0, 8'h50);
    wr(0, 8'hB8); wr(0, 8'h20); rd(0, d); check("R7 config operand", d, 8'hC0);
    wr(0, 8'h40); wr(12'h5AA, 8'h77);
    check("R6 no pgm to parked blk", {ps, busy}, 0);
    rd(0, d); check("R6 parked blk err", d, 8'hF0);
    wr(0, 8'h50);
    wr(0, 8'h40); wr(12'h812, 8'h66);
    check("R6 pgm pulse", ps, 1); check("R6 pgm addr", pgm_addr, 12'h812);
    rd(0, d); check("R6 status in pgm", d, 8'h40);
    count_busy(n); check("R6 pgm len", n, N);
    rd(0, d); check("R6 back to suspend", d, 8'hC0);
    wr(0, 8'hFF); wr(0, 8'hD0);
    check("R8 start", es, 1); check("R8 blk", eblk, 4'h5);
    rd(12'h123, d); check("R8 status read", d, 8'h00);
    count_busy(n); check("R8 remaining", n, E - 6);
    rd(0, d); check("R8 done", d, 8'h80);
  endtask

  task automatic t_held_resume();
    int i, es_idx; logic [7:0] d;
    suspend_erase(12'h200, 2);
    wr(0, 8'h40); wr(12'h900, 8'h11);
    check("R9 pgm pulse", ps, 1);
    wr(0, 8'hD0);
    rd(0, d); check("R9 susp held", d, 8'h40);
    check("R9 no early start", es, 0);
    i = 1; es_idx = -1;
    while (busy) begin
      if (es) es_idx = i;
      i++;
      @(negedge clk);
    end
    check("R9 start index", es_idx, N);
    check("R9 total busy", i, N + E - 3);
    rd(0, d); check("R9 done", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_suspend_resume();
    t_held_resume();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule